// File: doc/BRIEF.md
# Interrupt group enable register

This block holds a 32-bit control register, reachable only from the most privileged exception level. It carries two interrupt group enable bits, one for the non-secure state and one for the secure state. Each cycle it looks at a coprocessor-style system register request and checks whether the request names this register. If it does, the block decides from the current exception level, the hypervisor trap controls, the execution mode of the hypervisor level and the register-interface enable whether the access completes, is undefined, or traps to the hypervisor. It reports the result on a 2-bit status in the same cycle.

Lower-level enable registers in each security state see their own enable bit through a per-state alias port, and can write it through that port. When an enable bit goes from 1 to 0, by any path, the block raises a one-cycle release request for that security state. The surrounding logic uses it to hand a pending interrupt back so that another processing element can take it.

The request interface has no back-pressure. A request with `req_valid` high is always taken in the cycle it is presented. Its status and read data are combinational in that cycle, and a write takes effect at the next rising clock edge.

Top module: `grp_irq_enable_reg`

## Requirements
- R1: After reset both enable bits are 0. Bit 0 of the register is the non-secure enable and bit 1 is the secure enable. Bits 31:2 always read as 0, and writes to them have no effect.
- R2: A request hits only when coproc=4'b1111, opc1=3'b110, CRn=4'b1100 and CRm=4'b1100 (`req_crm`), and opc2=3'b111. Reads and writes use the same encoding, and `req_write` tells them apart. A miss drives `req_hit`=0, status 2'b00 and read data 0, and changes no state.
- R3: When `cur_el` (the exception level number) is 0 or 2, a hit gets status 2'b01 (undefined).
- R4: When `cur_el`=1, status is 2'b10 (trap through a 64-bit hypervisor) if `el2_enabled`, `el2_is_a64` and `hyp_trap_a64` are all 1. Status is 2'b11 (trap through a 32-bit hypervisor) if `el2_enabled` and `hyp_trap_a32` are 1 and `el2_is_a64` is 0. In every other case the status is 2'b01.
- R5: When `cur_el`=3, status is 2'b01 if `sysreg_if_en`=0 and 2'b00 (ok) otherwise. An ok read returns the register value on `req_rdata` in the same cycle. An ok write loads `req_wdata` at the next edge.
- R6: When `feat_present`=0, every hit gets status 2'b01.
- R7: A direct write whose status is not 2'b00 leaves both enable bits unchanged.
- R8: `alias_s_rdata` shows bit 1 and `alias_ns_rdata` shows bit 0. An alias write loads its bit at the next edge, and the new value is visible at once through the direct read and through the other alias.
- R9: When an enable bit goes from 1 to 0, its release output (`rel_s` for bit 1, `rel_ns` for bit 0) is 1 for exactly one cycle, starting at the edge where the bit becomes 0. Writes that go 0-to-0 or 1-to-1 raise no pulse.
- R10: If an ok direct write and an alias write target the same bit in the same cycle, the direct write's value wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| feat_present | input | 1 | The register exists in this configuration |
| req_valid | input | 1 | A system register request is present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_coproc | input | 4 | Coprocessor number field |
| req_opc1 | input | 3 | First opcode field |
| req_crn | input | 4 | Primary register field |
| req_crm | input | 4 | Secondary register field |
| req_opc2 | input | 3 | Second opcode field |
| req_wdata | input | 32 | Write data |
| cur_el | input | 2 | Current exception level number |
| el2_enabled | input | 1 | Hypervisor level is enabled |
| el2_is_a64 | input | 1 | Hypervisor level runs in 64-bit mode |
| hyp_trap_a64 | input | 1 | Trap bit of the 64-bit hypervisor trap register |
| hyp_trap_a32 | input | 1 | Trap bit of the 32-bit hypervisor trap register |
| sysreg_if_en | input | 1 | System register interface enable at the top level |
| req_hit | output | 1 | The request names this register |
| req_status | output | 2 | Access result: 00 ok, 01 undefined, 10 trap through 64-bit, 11 trap through 32-bit |
| req_rdata | output | 32 | Read data for an ok read, 0 otherwise |
| alias_s_we | input | 1 | Secure alias write strobe |
| alias_s_wdata | input | 1 | Secure alias write value |
| alias_s_rdata | output | 1 | Secure enable bit |
| alias_ns_we | input | 1 | Non-secure alias write strobe |
| alias_ns_wdata | input | 1 | Non-secure alias write value |
| alias_ns_rdata | output | 1 | Non-secure enable bit |
| rel_s | output | 1 | Release pulse on a falling secure enable |
| rel_ns | output | 1 | Release pulse on a falling non-secure enable |

## Verification
The bench builds the block with its default width of 32 bits, so the full reserved field above the two enable bits can be written and read back. With this build every exception level, every combination of trap bits and hypervisor mode, and a near-miss encoding are all reachable. A direct write and an alias write can also collide on the same bit in one cycle, and release pulses are checked against falling, steady and rising writes.

// File: rtl/grpen_pkg.sv
`timescale 1ns/1ps
package grpen_pkg;
  typedef enum logic [1:0] {
    ST_OK       = 2'b00,
    ST_UNDEF    = 2'b01,
    ST_TRAP_A64 = 2'b10,
    ST_TRAP_A32 = 2'b11
  } acc_status_e;

  localparam int COPROC_W = 4;
  localparam int OPC1_W   = 3;
  localparam int CRN_W    = 4;
  localparam int CRM_W    = 4;
  localparam int OPC2_W   = 3;
  localparam int EL_W     = 2;

  localparam logic [COPROC_W-1:0] MATCH_COPROC = 4'b1111;
  localparam logic [OPC1_W-1:0]   MATCH_OPC1   = 3'b110;
  localparam logic [CRN_W-1:0]    MATCH_CRN    = 4'b1100;
  localparam logic [CRM_W-1:0]    MATCH_CRM    = 4'b1100;
  localparam logic [OPC2_W-1:0]   MATCH_OPC2   = 3'b111;

  localparam logic [EL_W-1:0] LVL_USER  = 2'd0;
  localparam logic [EL_W-1:0] LVL_KERN  = 2'd1;
  localparam logic [EL_W-1:0] LVL_HYP   = 2'd2;
  localparam logic [EL_W-1:0] LVL_MON   = 2'd3;

  // bit positions of the enables (software decodes them)
  localparam int NUM_EN = 2;
  localparam int IDX_NS = 0;
  localparam int IDX_S  = 1;
endpackage

// File: rtl/grpen_access_check.sv
`timescale 1ns/1ps
module grpen_access_check
  import grpen_pkg::*;
(
  input  logic                feat_present,
  input  logic                req_valid,
  input  logic                req_write,
  input  logic [COPROC_W-1:0] req_coproc,
  input  logic [OPC1_W-1:0]   req_opc1,
  input  logic [CRN_W-1:0]    req_crn,
  input  logic [CRM_W-1:0]    req_crm,
  input  logic [OPC2_W-1:0]   req_opc2,
  input  logic [EL_W-1:0]     cur_el,
  input  logic                el2_enabled,
  input  logic                el2_is_a64,
  input  logic                hyp_trap_a64,
  input  logic                hyp_trap_a32,
  input  logic                sysreg_if_en,
  output logic                hit,
  output acc_status_e         status,
  output logic                wr_ok,
  output logic                rd_ok
);
  acc_status_e perm;

  assign hit = req_valid
            && (req_coproc == MATCH_COPROC) && (req_opc1 == MATCH_OPC1)
            && (req_crn == MATCH_CRN) && (req_crm == MATCH_CRM)
            && (req_opc2 == MATCH_OPC2);

  // layered permission decision
  always_comb begin
    perm = ST_UNDEF;
    if (feat_present) begin
      unique case (cur_el)
        LVL_KERN: begin
          if (el2_enabled && el2_is_a64 && hyp_trap_a64)
            perm = ST_TRAP_A64;
          else if (el2_enabled && !el2_is_a64 && hyp_trap_a32)
            perm = ST_TRAP_A32;
          else
            perm = ST_UNDEF;
        end
        LVL_MON:  perm = sysreg_if_en ? ST_OK : ST_UNDEF;
        default:  perm = ST_UNDEF;
      endcase
    end
  end

  assign status = hit ? perm : ST_OK;
  assign wr_ok  = hit && req_write  && (perm == ST_OK);
  assign rd_ok  = hit && !req_write && (perm == ST_OK);
endmodule

// File: rtl/grpen_store.sv
`timescale 1ns/1ps
module grpen_store #(
  parameter int NB = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dir_we,
  input  logic [NB-1:0] dir_wdata,
  input  logic [NB-1:0] alias_we,
  input  logic [NB-1:0] alias_wdata,
  output logic [NB-1:0] en_q,
  output logic [NB-1:0] en_nxt
);
  // alias writes first, direct write overrides
  always_comb begin
    en_nxt = en_q;
    for (int i = 0; i < NB; i++) begin
      if (alias_we[i]) en_nxt[i] = alias_wdata[i];
    end
    if (dir_we) en_nxt = dir_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= '0;
    else        en_q <= en_nxt;
  end

  // R7
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!dir_we && (alias_we == '0)) |=> $stable(en_q));

  // R10
  dir_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dir_we |=> (en_q == $past(dir_wdata)));
endmodule

// File: rtl/grpen_release.sv
`timescale 1ns/1ps
module grpen_release #(
  parameter int NB = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NB-1:0] en_q,
  input  logic [NB-1:0] en_nxt,
  output logic [NB-1:0] rel
);
  for (genvar g = 0; g < NB; g++) begin : g_rel
    logic rel_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rel_q <= 1'b0;
      else        rel_q <= en_q[g] & ~en_nxt[g];
    end
    assign rel[g] = rel_q;

    // R9
    rel_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rel_q |=> !rel_q);

    // R9
    rel_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en_q[g] && !en_nxt[g]) |=> (rel_q && !en_q[g]));
  end
endmodule

// File: rtl/grp_irq_enable_reg.sv
`timescale 1ns/1ps
module grp_irq_enable_reg
  import grpen_pkg::*;
#(
  parameter int REG_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             feat_present,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic [3:0]       req_coproc,
  input  logic [2:0]       req_opc1,
  input  logic [3:0]       req_crn,
  input  logic [3:0]       req_crm,
  input  logic [2:0]       req_opc2,
  input  logic [REG_W-1:0] req_wdata,
  input  logic [1:0]       cur_el,
  input  logic             el2_enabled,
  input  logic             el2_is_a64,
  input  logic             hyp_trap_a64,
  input  logic             hyp_trap_a32,
  input  logic             sysreg_if_en,
  output logic             req_hit,
  output logic [1:0]       req_status,
  output logic [REG_W-1:0] req_rdata,
  input  logic             alias_s_we,
  input  logic             alias_s_wdata,
  output logic             alias_s_rdata,
  input  logic             alias_ns_we,
  input  logic             alias_ns_wdata,
  output logic             alias_ns_rdata,
  output logic             rel_s,
  output logic             rel_ns
);
  localparam int RSV_W = REG_W - NUM_EN;

  acc_status_e        status;
  logic               wr_ok, rd_ok;
  logic [NUM_EN-1:0]  en_q, en_nxt, al_we, al_wd, rel;
  logic [RSV_W-1:0]   unused_rsv_wdata;

  assign unused_rsv_wdata = req_wdata[REG_W-1:NUM_EN];

  grpen_access_check u_chk (
    .feat_present (feat_present),
    .req_valid    (req_valid),
    .req_write    (req_write),
    .req_coproc   (req_coproc),
    .req_opc1     (req_opc1),
    .req_crn      (req_crn),
    .req_crm      (req_crm),
    .req_opc2     (req_opc2),
    .cur_el       (cur_el),
    .el2_enabled  (el2_enabled),
    .el2_is_a64   (el2_is_a64),
    .hyp_trap_a64 (hyp_trap_a64),
    .hyp_trap_a32 (hyp_trap_a32),
    .sysreg_if_en (sysreg_if_en),
    .hit          (req_hit),
    .status       (status),
    .wr_ok        (wr_ok),
    .rd_ok        (rd_ok)
  );

  assign al_we[IDX_S]  = alias_s_we;
  assign al_we[IDX_NS] = alias_ns_we;
  assign al_wd[IDX_S]  = alias_s_wdata;
  assign al_wd[IDX_NS] = alias_ns_wdata;

  grpen_store #(.NB(NUM_EN)) u_store (
    .clk         (clk),
    .rst_n       (rst_n),
    .dir_we      (wr_ok),
    .dir_wdata   (req_wdata[NUM_EN-1:0]),
    .alias_we    (al_we),
    .alias_wdata (al_wd),
    .en_q        (en_q),
    .en_nxt      (en_nxt)
  );

  grpen_release #(.NB(NUM_EN)) u_rel (
    .clk    (clk),
    .rst_n  (rst_n),
    .en_q   (en_q),
    .en_nxt (en_nxt),
    .rel    (rel)
  );

  assign req_status     = status;
  assign req_rdata      = rd_ok ? {{RSV_W{1'b0}}, en_q} : '0;
  assign alias_s_rdata  = en_q[IDX_S];
  assign alias_ns_rdata = en_q[IDX_NS];
  assign rel_s          = rel[IDX_S];
  assign rel_ns         = rel[IDX_NS];

  // R1
  rsv_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_rdata[REG_W-1:NUM_EN] == '0);

  // R6
  feat_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_hit && !feat_present) |-> (req_status == 2'b01));

  // R3
  low_el_undef_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_hit && (cur_el == 2'd0 || cur_el == 2'd2)) |-> (req_status == 2'b01));

  // R5
  ok_only_mon_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_hit && req_status == 2'b00) |-> (cur_el == 2'd3 && sysreg_if_en && feat_present));

  // R2
  miss_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_hit |-> (req_status == 2'b00 && req_rdata == '0));
endmodule

// File: tb/grp_irq_enable_reg_test.sv
`timescale 1ns/1ps
module grp_irq_enable_reg_test;
  logic        clk = 0, rst_n = 0;
  logic        feat_present = 1, req_valid = 0, req_write = 0;
  logic [3:0]  req_coproc = 4'b1111, req_crn = 4'b1100, req_crm = 4'b1100;
  logic [2:0]  req_opc1 = 3'b110, req_opc2 = 3'b111;
  logic [31:0] req_wdata = '0;
  logic [1:0]  cur_el = 2'd3;
  logic        el2_enabled = 0, el2_is_a64 = 0, hyp_trap_a64 = 0, hyp_trap_a32 = 0;
  logic        sysreg_if_en = 1;
  logic        req_hit;
  logic [1:0]  req_status;
  logic [31:0] req_rdata;
  logic        alias_s_we = 0, alias_s_wdata = 0, alias_s_rdata;
  logic        alias_ns_we = 0, alias_ns_wdata = 0, alias_ns_rdata;
  logic        rel_s, rel_ns;

  int checks = 0, failures = 0;

  always #10 clk = ~clk;

  grp_irq_enable_reg uut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one request cycle; status/rdata sampled mid-cycle, returns after the edge
  task automatic acc(input logic wr, input logic [1:0] el, input logic [31:0] wd,
                     output logic [1:0] st, output logic [31:0] rd, output logic h);
    @(negedge clk);
    req_valid = 1; req_write = wr; cur_el = el; req_wdata = wd;
    #2;
    st = req_status; rd = req_rdata; h = req_hit;
    @(posedge clk); #1;
    req_valid = 0; req_write = 0;
  endtask

  task automatic read_reg(output logic [31:0] v);
    logic [1:0] st; logic h;
    acc(1'b0, 2'd3, '0, st, v, h);
  endtask

  task automatic wr_reg(input logic [31:0] v);
    logic [1:0] st; logic [31:0] rd; logic h;
    acc(1'b1, 2'd3, v, st, rd, h);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    chk("R1 reset alias_s", alias_s_rdata, 0);
    chk("R1 reset alias_ns", alias_ns_rdata, 0);
    chk("R9 reset rel", {rel_s, rel_ns}, 0);
    read_reg(v);
    chk("R1 reset read", v, 0);
  endtask

  task automatic t_mon_rw();
    logic [1:0] st; logic [31:0] rd; logic h;
    acc(1'b1, 2'd3, 32'hFFFF_FFFE, st, rd, h);
    chk("R5 ok write status", st, 2'b00);
    chk("R2 hit", h, 1);
    read_reg(rd);
    chk("R1 reserved ignored, bit1 set", rd, 32'h2);
    chk("R8 alias_s view", alias_s_rdata, 1);
    chk("R8 alias_ns view", alias_ns_rdata, 0);
    wr_reg(32'h1);
    read_reg(rd);
    chk("R5 write 1 readback", rd, 32'h1);
    wr_reg(32'h3);
  endtask

  task automatic t_low_el();
    logic [1:0] st; logic [31:0] rd; logic h;
    acc(1'b1, 2'd0, 32'h0, st, rd, h);
    chk("R3 EL0 undef", st, 2'b01);
    acc(1'b0, 2'd2, 32'h0, st, rd, h);
    chk("R3 EL2 undef", st, 2'b01);
    chk("R3 EL2 rdata zero", rd, 0);
    read_reg(rd);
    chk("R7 state kept after undef writes", rd, 32'h3);
  endtask

  task automatic t_el1();
    logic [1:0] st; logic [31:0] rd; logic h;
    for (int k = 0; k < 16; k++) begin
      logic [1:0] exp;
      el2_enabled = k[3]; el2_is_a64 = k[2]; hyp_trap_a64 = k[1]; hyp_trap_a32 = k[0];
      if (k[3] && k[2] && k[1]) exp = 2'b10;
      else if (k[3] && !k[2] && k[0]) exp = 2'b11;
      else exp = 2'b01;
      acc(1'b1, 2'd1, 32'h0, st, rd, h);
      chk($sformatf("R4 EL1 combo %0d", k), st, exp);
    end
    el2_enabled = 0; el2_is_a64 = 0; hyp_trap_a64 = 0; hyp_trap_a32 = 0;
    read_reg(rd);
    chk("R7 state kept after traps", rd, 32'h3);
    chk("R9 no release on trapped write", {rel_s, rel_ns}, 0);
  endtask

  task automatic t_sre_off();
    logic [1:0] st; logic [31:0] rd; logic h;
    sysreg_if_en = 0;
    acc(1'b1, 2'd3, 32'h0, st, rd, h);
    chk("R5 interface disabled undef", st, 2'b01);
    sysreg_if_en = 1;
    read_reg(rd);
    chk("R7 state kept after disabled write", rd, 32'h3);
  endtask

  task automatic t_feat_off();
    logic [1:0] st; logic [31:0] rd; logic h;
    feat_present = 0;
    acc(1'b1, 2'd3, 32'h0, st, rd, h);
    chk("R6 feature absent undef", st, 2'b01);
    acc(1'b0, 2'd1, 32'h0, st, rd, h);
    chk("R6 feature absent EL1 undef", st, 2'b01);
    feat_present = 1;
    read_reg(rd);
    chk("R7 state kept with feature absent", rd, 32'h3);
  endtask

  task automatic t_miss();
    logic [1:0] st; logic [31:0] rd; logic h;
    req_crm = 4'b1101;
    acc(1'b1, 2'd3, 32'h0, st, rd, h);
    chk("R2 miss hit", h, 0);
    chk("R2 miss status", st, 2'b00);
    req_crm = 4'b1100; req_opc2 = 3'b110;
    acc(1'b0, 2'd3, 32'h0, st, rd, h);
    chk("R2 miss rdata", rd, 0);
    req_opc2 = 3'b111;
    read_reg(rd);
    chk("R2 miss no effect", rd, 32'h3);
  endtask

  task automatic t_alias();
    logic [31:0] rd;
    @(negedge clk); alias_s_we = 1; alias_s_wdata = 0;
    @(posedge clk); #1; alias_s_we = 0;
    chk("R8 alias_s write", alias_s_rdata, 0);
    chk("R9 release secure via alias", rel_s, 1);
    read_reg(rd);
    chk("R8 alias write seen directly", rd, 32'h1);
    @(negedge clk); alias_s_we = 1; alias_s_wdata = 1; alias_ns_we = 1; alias_ns_wdata = 0;
    @(posedge clk); #1; alias_s_we = 0; alias_ns_we = 0;
    chk("R8 both alias writes", {alias_s_rdata, alias_ns_rdata}, 2'b10);
    chk("R9 release ns via alias", {rel_s, rel_ns}, 2'b01);
    wr_reg(32'h3);
  endtask

  task automatic t_release();
    @(posedge clk); #1;
    wr_reg(32'h1);
    chk("R9 secure pulse", {rel_s, rel_ns}, 2'b10);
    @(posedge clk); #1;
    chk("R9 pulse one cycle", {rel_s, rel_ns}, 2'b00);
    wr_reg(32'h1);
    chk("R9 no pulse 1-to-1 / 0-to-0", {rel_s, rel_ns}, 2'b00);
    wr_reg(32'h3);
    chk("R9 no pulse on rise", {rel_s, rel_ns}, 2'b00);
    wr_reg(32'h0);
    chk("R9 both pulse", {rel_s, rel_ns}, 2'b11);
    @(posedge clk); #1;
    chk("R9 both pulses end", {rel_s, rel_ns}, 2'b00);
  endtask

  task automatic t_prio();
    logic [31:0] rd;
    wr_reg(32'h0);
    @(negedge clk);
    req_valid = 1; req_write = 1; cur_el = 2'd3; req_wdata = 32'h1;
    alias_s_we = 1; alias_s_wdata = 1; alias_ns_we = 1; alias_ns_wdata = 0;
    @(posedge clk); #1;
    req_valid = 0; req_write = 0; alias_s_we = 0; alias_ns_we = 0;
    read_reg(rd);
    chk("R10 direct beats alias", rd, 32'h1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    t_reset();
    t_mon_rw();
    t_low_el();
    t_el1();
    t_sre_off();
    t_feat_off();
    t_miss();
    t_alias();
    t_release();
    t_prio();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule